// File: doc/BRIEF.md
# ADC control and status register

This block is the 16-bit control and status register of an analog-to-digital converter controller. It sits on a simple CPU bus that writes the low byte and the high byte separately and reads all 16 bits at once. It holds the conversion mode, the channel range, the start-source select, the pause bit and the interrupt enable. It sends one-cycle start and forced-stop pulses to the conversion engine. It follows a busy flag from the engine's started and ended events, and it keeps a completion flag that drives an interrupt request.

The completion flag is set when the engine reports a result write. Software clears it by writing zero to it. A data-transfer helper can also clear it with a strobe. How busy behaves at the end of a conversion depends on the mode. In single mode the end event clears busy. In continuous and stop modes busy stays set until software writes zero to it, and that write aborts the running conversion.

Top module: `adc_ctrl_stat`

## Requirements
- R1: After reset every register bit reads 0, and `irq_o`, `start_sw_o` and `stop_o` are low.
- R2: `evt_start_i` sets busy (bit 15) on the next clock. In single mode (bit 7 = 0, that is mode 00 or 01), `evt_end_i` clears busy on the next clock.
- R3: In continuous mode (bits 7:6 = 10) and stop mode (11), `evt_end_i` leaves busy set.
- R4: A high-byte write with bit 15 = 0 while busy is 1 clears busy and raises `stop_o` for exactly one cycle, in the cycle after the write. The same write while busy is 0 gives no pulse. Writing 1 to bit 15 does not change busy. Busy priority, highest first: software stop, then `evt_start_i`, then `evt_end_i`.
- R5: Bit 14 (completion) is set by `evt_result_i`. Writing 1 to it has no effect. A high-byte write with bit 14 = 0 clears it, and so does `dma_clr_i`.
- R6: `irq_o` is high exactly while bit 14 and bit 13 (interrupt enable) are both 1.
- R7: A high-byte write with bit 9 = 1 and bit 15 = 1 raises `start_sw_o` for one cycle, in the cycle after the write. Bits 9 and 8 always read as 0.
- R8: The read/write fields read back as written: pause at bit 12, start source at bits 11:10, enable at bit 13, mode at bits 7:6, first channel at bits 5:3, last channel at bits 2:0.
- R9: Low-byte writes are ignored while busy is 1.
- R10: A high-byte write with bit 9 = 1 and bit 15 = 0 issues no start pulse. If busy is 1, that write is treated as a stop.
- R11: When `evt_result_i` and a clear of the completion flag happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write strobe for bits 7:0 |
| wr_hi_i | input | 1 | Write strobe for bits 15:8 |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Register read value |
| evt_start_i | input | 1 | Engine reports that a conversion has started |
| evt_end_i | input | 1 | Engine reports that a conversion has ended |
| evt_result_i | input | 1 | Engine reports that a result was written |
| dma_clr_i | input | 1 | Completion clear strobe from the transfer helper |
| start_sw_o | output | 1 | Software start pulse |
| stop_o | output | 1 | Forced-stop pulse |
| irq_o | output | 1 | Interrupt request |
| mode_o | output | 2 | Mode field |
| src_o | output | 2 | Start-source field |
| pause_o | output | 1 | Pause field |
| ch_first_o | output | 3 | First channel |
| ch_last_o | output | 3 | Last channel |

## Verification
The hardest situations to reach are same-cycle collisions. One is a result event arriving in the same cycle as a software clear of the completion flag. The other is a write that asks for a start and a stop at once while a conversion is running. The bench first drives a started event so that busy is set. It then aligns the colliding stimulus on a single clock edge from one negative-edge drive, and reads both the register and the pulse outputs one cycle later.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    MODE_SINGLE_A = 2'b00,
    MODE_SINGLE_B = 2'b01,
    MODE_CONT     = 2'b10,
    MODE_STOP     = 2'b11
  } adc_mode_e;

  function automatic logic is_single(input logic [1:0] m);
    return (m == MODE_SINGLE_A) || (m == MODE_SINGLE_B);
  endfunction
endpackage

// File: rtl/adc_csr_cfg.sv
module adc_csr_cfg #(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             busy_i,
  input  logic [1:0]       mode_d_i,
  input  logic [CH_W-1:0]  first_d_i,
  input  logic [CH_W-1:0]  last_d_i,
  input  logic             inte_d_i,
  input  logic             pause_d_i,
  input  logic [SRC_W-1:0] src_d_i,
  output logic [1:0]       mode_o,
  output logic [CH_W-1:0]  first_o,
  output logic [CH_W-1:0]  last_o,
  output logic             inte_o,
  output logic             pause_o,
  output logic [SRC_W-1:0] src_o
);
  // low byte frozen during conversion
  logic lo_en;
  assign lo_en = wr_lo_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      first_o <= '0;
      last_o  <= '0;
    end else if (lo_en) begin
      mode_o  <= mode_d_i;
      first_o <= first_d_i;
      last_o  <= last_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inte_o  <= 1'b0;
      pause_o <= 1'b0;
      src_o   <= '0;
    end else if (wr_hi_i) begin
      inte_o  <= inte_d_i;
      pause_o <= pause_d_i;
      src_o   <= src_d_i;
    end
  end
endmodule

// File: rtl/adc_csr_busy.sv
module adc_csr_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hi_i,
  input  logic busy_wr_i,
  input  logic strt_wr_i,
  input  logic single_i,
  input  logic evt_start_i,
  input  logic evt_end_i,
  output logic busy_o,
  output logic start_o,
  output logic stop_o
);
  logic sw_stop, sw_start;
  assign sw_stop  = wr_hi_i && !busy_wr_i && busy_o;
  // stop/start collision: no start when busy bit written 0
  assign sw_start = wr_hi_i && strt_wr_i && busy_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= sw_start;
      stop_o  <= sw_stop;
      if (sw_stop)                     busy_o <= 1'b0;
      else if (evt_start_i)            busy_o <= 1'b1;
      else if (evt_end_i && single_i)  busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_csr_flag.sv
module adc_csr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_result_i,
  input  logic sw_clr_i,
  input  logic dma_clr_i,
  input  logic inte_i,
  output logic done_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     done_o <= 1'b0;
    else if (evt_result_i)           done_o <= 1'b1;
    else if (sw_clr_i || dma_clr_i)  done_o <= 1'b0;
  end

  assign irq_o = done_o && inte_i;
endmodule

// File: rtl/adc_ctrl_stat.sv
module adc_ctrl_stat
  import adc_csr_pkg::*;
#(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned SRC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              evt_start_i,
  input  logic              evt_end_i,
  input  logic              evt_result_i,
  input  logic              dma_clr_i,
  output logic              start_sw_o,
  output logic              stop_o,
  output logic              irq_o,
  output logic [1:0]        mode_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              pause_o,
  output logic [CH_W-1:0]   ch_first_o,
  output logic [CH_W-1:0]   ch_last_o
);
  localparam int unsigned LAST_LSB  = 0;
  localparam int unsigned FIRST_LSB = LAST_LSB + CH_W;
  localparam int unsigned MODE_LSB  = FIRST_LSB + CH_W;
  localparam int unsigned SRC_LSB   = 10;
  localparam int unsigned PAUSE_BIT = SRC_LSB + SRC_W;
  localparam int unsigned INTE_BIT  = 13;
  localparam int unsigned DONE_BIT  = 14;
  localparam int unsigned BUSY_BIT  = 15;
  localparam int unsigned STRT_BIT  = 9;

  logic busy, done, inte;

  adc_csr_cfg #(.CH_W(CH_W), .SRC_W(SRC_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .busy_i    (busy),
    .mode_d_i  (wdata_i[MODE_LSB +: 2]),
    .first_d_i (wdata_i[FIRST_LSB +: CH_W]),
    .last_d_i  (wdata_i[LAST_LSB +: CH_W]),
    .inte_d_i  (wdata_i[INTE_BIT]),
    .pause_d_i (wdata_i[PAUSE_BIT]),
    .src_d_i   (wdata_i[SRC_LSB +: SRC_W]),
    .mode_o    (mode_o),
    .first_o   (ch_first_o),
    .last_o    (ch_last_o),
    .inte_o    (inte),
    .pause_o   (pause_o),
    .src_o     (src_o)
  );

  adc_csr_busy i_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_hi_i     (wr_hi_i),
    .busy_wr_i   (wdata_i[BUSY_BIT]),
    .strt_wr_i   (wdata_i[STRT_BIT]),
    .single_i    (is_single(mode_o)),
    .evt_start_i (evt_start_i),
    .evt_end_i   (evt_end_i),
    .busy_o      (busy),
    .start_o     (start_sw_o),
    .stop_o      (stop_o)
  );

  adc_csr_flag i_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_result_i (evt_result_i),
    .sw_clr_i     (wr_hi_i && !wdata_i[DONE_BIT]),
    .dma_clr_i    (dma_clr_i),
    .inte_i       (inte),
    .done_o       (done),
    .irq_o        (irq_o)
  );

  always_comb begin
    rdata_o                       = '0;
    rdata_o[BUSY_BIT]             = busy;
    rdata_o[DONE_BIT]             = done;
    rdata_o[INTE_BIT]             = inte;
    rdata_o[PAUSE_BIT]            = pause_o;
    rdata_o[SRC_LSB +: SRC_W]     = src_o;
    rdata_o[MODE_LSB +: 2]        = mode_o;
    rdata_o[FIRST_LSB +: CH_W]    = ch_first_o;
    rdata_o[LAST_LSB +: CH_W]     = ch_last_o;
  end
endmodule

// File: rtl/adc_ctrl_stat_chk.sv
module adc_ctrl_stat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_lo_i,
  input logic        wr_hi_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        evt_start_i,
  input logic        evt_end_i,
  input logic        evt_result_i,
  input logic        start_sw_o,
  input logic        stop_o,
  input logic        irq_o
);
  a_r2_single_end_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[15] && !rdata_o[7] && evt_end_i && !evt_start_i |=> !rdata_o[15]);

  a_r3_cont_end_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[15] && rdata_o[7] && evt_end_i && !wr_hi_i |=> rdata_o[15]);

  a_r4_stop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && !wdata_i[15] && rdata_o[15] |=> stop_o && !rdata_o[15]);

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rdata_o[14] && rdata_o[13]);

  a_r7_strt_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[9:8] == 2'b00);

  a_r9_lo_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && rdata_o[15] |=> $stable(rdata_o[7:0]));

  a_r10_no_start_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && !wdata_i[15] |=> !start_sw_o);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_result_i |=> rdata_o[14]);
endmodule

bind adc_ctrl_stat adc_ctrl_stat_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_lo_i      (wr_lo_i),
  .wr_hi_i      (wr_hi_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .evt_start_i  (evt_start_i),
  .evt_end_i    (evt_end_i),
  .evt_result_i (evt_result_i),
  .start_sw_o   (start_sw_o),
  .stop_o       (stop_o),
  .irq_o        (irq_o)
);

// File: tb/test_adc_ctrl_stat.sv
module test_adc_ctrl_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt_start = 1'b0, evt_end = 1'b0, evt_result = 1'b0, dma_clr = 1'b0;
  logic        start_sw, stop, irq;
  logic [1:0]  mode, src;
  logic        pause;
  logic [2:0]  ch_first, ch_last;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  adc_ctrl_stat i_adc_ctrl_stat (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .rdata_o(rdata), .evt_start_i(evt_start), .evt_end_i(evt_end),
    .evt_result_i(evt_result), .dma_clr_i(dma_clr), .start_sw_o(start_sw),
    .stop_o(stop), .irq_o(irq), .mode_o(mode), .src_o(src), .pause_o(pause),
    .ch_first_o(ch_first), .ch_last_o(ch_last)
  );

  // {op[1:0], wdata, expected rdata}; op 0 = low write, 1 = high write
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 16'h00B5, 16'h00B5},
    {2'd1, 16'h3C00, 16'h3CB5},
    {2'd1, 16'h4000, 16'h00B5},
    {2'd1, 16'h0200, 16'h00B5},
    {2'd0, 16'h0000, 16'h0000},
    {2'd1, 16'h8100, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic hi, input logic [15:0] d);
    wr_hi = hi; wr_lo = !hi; wdata = d;
    cyc();
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic pulse_start(); evt_start = 1'b1; cyc(); evt_start = 1'b0; endtask
  task automatic pulse_end();   evt_end = 1'b1;   cyc(); evt_end = 1'b0;   endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 outs", {13'd0, irq, start_sw, stop}, 16'h0000);
    rst_n = 1'b1;
    cyc();

    // R8 readback table, no conversion active
    foreach (VEC[i]) begin
      wr(VEC[i][32], VEC[i][31:16]);
      chk("R8 table", rdata, VEC[i][15:0]);
      if (i == 3) chk("R10 no start when busy bit 0", {15'd0, start_sw}, 16'h0000);
    end
    wr(1'b1, 16'h0000);
    chk("R4 no stop when idle", {15'd0, stop}, 16'h0000);

    // R7 software start
    wr(1'b1, 16'h8200);
    chk("R7 start pulse", {15'd0, start_sw}, 16'h0001);
    cyc();
    chk("R7 start one cycle", {15'd0, start_sw}, 16'h0000);

    // single mode
    wr(1'b1, 16'h2000);
    pulse_start();
    chk("R2 busy set", rdata, 16'hA000);
    wr(1'b0, 16'h00FF);
    chk("R9 low byte locked", rdata, 16'hA000);
    evt_result = 1'b1; cyc(); evt_result = 1'b0;
    chk("R5 flag set", rdata, 16'hE000);
    chk("R6 irq on", {15'd0, irq}, 16'h0001);
    pulse_end();
    chk("R2 single end clears busy", rdata, 16'h6000);
    dma_clr = 1'b1; cyc(); dma_clr = 1'b0;
    chk("R5 dma clear", rdata, 16'h2000);
    chk("R6 irq off", {15'd0, irq}, 16'h0000);

    // R11 set beats software clear
    evt_result = 1'b1; wr(1'b1, 16'h2000); evt_result = 1'b0;
    chk("R11 set wins", rdata, 16'h6000);
    wr(1'b1, 16'h2000);
    chk("R5 write 0 clears", rdata, 16'h2000);

    // continuous mode
    wr(1'b0, 16'h0080);
    pulse_start();
    pulse_end();
    chk("R3 cont holds busy", rdata, 16'hA080);
    wr(1'b1, 16'hA000);
    chk("R4 write 1 keeps busy", rdata, 16'hA080);
    wr(1'b1, 16'h2000);
    chk("R4 stop clears busy", rdata, 16'h2080);
    chk("R4 stop pulse", {15'd0, stop}, 16'h0001);
    cyc();
    chk("R4 stop one cycle", {15'd0, stop}, 16'h0000);

    // stop mode, collision write
    wr(1'b0, 16'h00C0);
    pulse_start();
    pulse_end();
    chk("R3 stop mode holds busy", rdata, 16'hA0C0);
    wr(1'b1, 16'h0200);
    chk("R10 collision stops", rdata, 16'h00C0);
    chk("R10 pulses", {14'd0, start_sw, stop}, 16'h0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule